// File: doc/BRIEF.md
# String Operation Repeat Controller

This block is a sequencer that carries out repeated string operations one element at a time against a byte-wide synchronous memory port. It owns the source pointer, destination pointer, count register, accumulator and direction flag. A single command names the operation (move, compare, scan, load or store), the element width (byte or word) and a repeat mode (single, unconditional repeat, repeat while equal, repeat while not equal). The controller then issues memory reads and writes, steps the pointers, counts down, updates the zero flag for compare and scan, and pulses done when the command is complete.

The surrounding logic preloads the architectural registers through a load strobe while the block is idle, issues a command, and waits for the done pulse. A word element is two byte accesses, low byte at the pointer and high byte at the pointer plus one. Memory read data returns in the cycle after the request.

Top module: `strop_seq`

## Requirements
- R1: After reset busy, done, mem_req and mem_we are low, and si, di, cx, acc, dir and zf are all zero.
- R2: Each processed element steps a used pointer by 1 for byte or 2 for word, upward when dir is 0 and downward when dir is 1; move and compare step both pointers, load steps only si, scan and store step only di; an unused pointer keeps its value.
- R3: Move copies the element at si to the element at di; a word element occupies address p (low byte) and p+1 (high byte) for pointer value p.
- R4: Load puts the element at si into acc (byte: only acc[7:0] changes); store writes acc[7:0] (byte) or acc[15:0] (word) to the element at di.
- R5: Compare sets zf to 1 exactly when the element at si equals the element at di; scan sets zf to 1 exactly when acc (acc[7:0] for byte) equals the element at di; neither writes memory, and all other operations leave zf unchanged.
- R6: With repeat code 0 (single) exactly one element is processed and cx keeps its value.
- R7: With repeat codes 1, 2 or 3, cx is tested before every element: if it is zero the command ends with no memory request; otherwise one element is processed and cx drops by one, ending when cx reaches zero.
- R8: Repeat code 2 ends a compare or scan after an element leaving zf at 0; repeat code 3 ends it after an element leaving zf at 1; for move, load and store codes 2 and 3 act like code 1.
- R9: Every memory request is made while busy, mem_we is high only with mem_req, and read data is taken from mem_rdata one cycle after the read request.
- R10: busy rises the cycle after a command is accepted and stays high through a one-cycle done pulse, falling the cycle after it; a command or register load presented while busy has no effect.
- R11: Command encoding: cmd_op 0 move, 1 compare, 2 scan, 3 load, 4 store; codes 5 to 7 are not accepted and leave busy low and all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load si, di, cx, acc, dir from the cfg inputs while idle |
| cfg_si | input | AW | Source pointer value to load |
| cfg_di | input | AW | Destination pointer value to load |
| cfg_cx | input | CW | Count value to load |
| cfg_acc | input | 16 | Accumulator value to load |
| cfg_dir | input | 1 | Direction value to load (1 = downward) |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Operation code |
| cmd_rep | input | 2 | Repeat code: 0 single, 1 unconditional, 2 while equal, 3 while not equal |
| cmd_word | input | 1 | 1 = word elements, 0 = byte elements |
| si | output | AW | Source pointer |
| di | output | AW | Destination pointer |
| cx | output | CW | Count register |
| acc | output | 16 | Accumulator |
| dir | output | 1 | Direction flag |
| zf | output | 1 | Zero flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
A wrong captured byte or a mis-stepped pointer shows at the ports at the end of the very command that caused it, through si, di, acc or zf, or through memory contents; stray or mis-addressed writes appear in the memory image the bench compares after every command. A wrong stop decision in the repeat modes changes cx and both pointers at done, and a miscounted element shows as a request count that differs from zero in the zero-count case. A stuck sequencer is seen as a missing done pulse within a bounded number of cycles.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } str_op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SRC_RQ,
    ST_SRC_CAP,
    ST_DST_RQ,
    ST_DST_CAP,
    ST_WR,
    ST_END,
    ST_DONE
  } seq_st_e;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic reads_src(input str_op_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  function automatic logic reads_dst(input str_op_e op);
    return (op == OP_CMP) || (op == OP_SCAN);
  endfunction

  function automatic logic writes_dst(input str_op_e op);
    return (op == OP_MOVE) || (op == OP_STORE);
  endfunction

  function automatic logic steps_si(input str_op_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  function automatic logic steps_di(input str_op_e op);
    return (op != OP_LOAD);
  endfunction

  function automatic logic compares(input str_op_e op);
    return (op == OP_CMP) || (op == OP_SCAN);
  endfunction

endpackage

// File: rtl/strop_step.sv
module strop_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic          down,
  input  logic          word,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] delta;

  always_comb begin
    delta = word ? AW'(2) : AW'(1);
    nxt   = down ? (ptr - delta) : (ptr + delta);
  end
endmodule

// File: rtl/strop_cmpz.sv
module strop_cmpz #(
  parameter int BW = 8
) (
  input  logic [2*BW-1:0] lhs,
  input  logic [2*BW-1:0] rhs,
  input  logic            word,
  output logic            is_zero
);
  logic [2*BW-1:0] diff;

  always_comb begin
    diff    = lhs - rhs;
    is_zero = word ? (diff == '0) : (diff[BW-1:0] == '0);
  end
endmodule

// File: rtl/strop_fsm.sv
module strop_fsm
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_rep,
  input  logic       cmd_word,
  input  logic       cx_zero,
  input  logic       cx_last,
  input  logic       zf_now,
  output logic       busy,
  output logic       done,
  output logic       mem_req,
  output logic       mem_we,
  output logic       use_di,
  output logic       byte_sel,
  output logic       cap_src,
  output logic       cap_dst,
  output logic       elem_end,
  output str_op_e    op_q,
  output rep_e       rep_q,
  output logic       word_q
);
  seq_st_e st_q, st_d;
  logic    byte_q, byte_d;
  logic    accept;
  logic    zstop;

  assign accept = cmd_valid && (st_q == ST_IDLE) && op_legal(cmd_op);
  assign zstop  = compares(op_q) &&
                  (((rep_q == RP_EQ) && !zf_now) || ((rep_q == RP_NE) && zf_now));

  always_comb begin
    st_d     = st_q;
    byte_d   = byte_q;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    use_di   = 1'b0;
    cap_src  = 1'b0;
    cap_dst  = 1'b0;
    elem_end = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        byte_d = 1'b0;
        if ((rep_q != RP_NONE) && cx_zero) st_d = ST_DONE;
        else if (reads_src(op_q))          st_d = ST_SRC_RQ;
        else if (reads_dst(op_q))          st_d = ST_DST_RQ;
        else                               st_d = ST_WR;
      end
      ST_SRC_RQ: begin
        mem_req = 1'b1;
        st_d    = ST_SRC_CAP;
      end
      ST_SRC_CAP: begin
        cap_src = 1'b1;
        if (word_q && !byte_q) begin
          byte_d = 1'b1;
          st_d   = ST_SRC_RQ;
        end else begin
          byte_d = 1'b0;
          if (reads_dst(op_q))       st_d = ST_DST_RQ;
          else if (writes_dst(op_q)) st_d = ST_WR;
          else                       st_d = ST_END;
        end
      end
      ST_DST_RQ: begin
        mem_req = 1'b1;
        use_di  = 1'b1;
        st_d    = ST_DST_CAP;
      end
      ST_DST_CAP: begin
        cap_dst = 1'b1;
        if (word_q && !byte_q) begin
          byte_d = 1'b1;
          st_d   = ST_DST_RQ;
        end else begin
          byte_d = 1'b0;
          st_d   = ST_END;
        end
      end
      ST_WR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        use_di  = 1'b1;
        if (word_q && !byte_q) begin
          byte_d = 1'b1;
        end else begin
          byte_d = 1'b0;
          st_d   = ST_END;
        end
      end
      ST_END: begin
        elem_end = 1'b1;
        if ((rep_q == RP_NONE) || cx_last || zstop) st_d = ST_DONE;
        else                                        st_d = ST_CHECK;
      end
      ST_DONE: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy     = (st_q != ST_IDLE);
  assign byte_sel = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      byte_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      byte_q <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MOVE;
      rep_q  <= RP_NONE;
      word_q <= 1'b0;
    end else if (accept) begin
      op_q   <= str_op_e'(cmd_op);
      rep_q  <= rep_e'(cmd_rep);
      word_q <= cmd_word;
    end
  end

  // R10: completion pulse lasts one cycle and busy follows it down
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: requests only while busy, writes only as requests
  a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  a_r9_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  // R5: compare and scan never write memory
  a_r5_no_write_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && busy) |-> writes_dst(op_q));
  // R7: zero count under a repeat ends with no memory access
  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CHECK) && (rep_q != RP_NONE) && cx_zero) |=> (done && !mem_req));
  // R11: illegal operation codes leave the block idle
  a_r11_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !op_legal(cmd_op)) |=> !busy);

endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_si,
  input  logic [AW-1:0] cfg_di,
  input  logic [CW-1:0] cfg_cx,
  input  logic [15:0]   cfg_acc,
  input  logic          cfg_dir,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_rep,
  input  logic          cmd_word,
  output logic [AW-1:0] si,
  output logic [AW-1:0] di,
  output logic [CW-1:0] cx,
  output logic [15:0]   acc,
  output logic          dir,
  output logic          zf,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int BW    = 8;
  localparam int LANES = 2;
  localparam int WW    = BW * LANES;

  logic [AW-1:0] si_q, si_d, di_q, di_d;
  logic [CW-1:0] cx_q, cx_d;
  logic [WW-1:0] acc_q, acc_d;
  logic          dir_q, dir_d, zf_q, zf_d;
  logic [WW-1:0] opa_w, opb_w;
  logic [AW-1:0] si_nx, di_nx, base;
  logic [WW-1:0] cmp_lhs, wsrc;
  logic          eq_w;

  logic    busy_w, use_di, byte_sel, cap_src, cap_dst, elem_end;
  str_op_e op_q;
  rep_e    rep_q;
  logic    word_q;

  strop_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_rep  (cmd_rep),
    .cmd_word (cmd_word),
    .cx_zero  (cx_q == '0),
    .cx_last  (cx_q == CW'(1)),
    .zf_now   (eq_w),
    .busy     (busy_w),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .use_di   (use_di),
    .byte_sel (byte_sel),
    .cap_src  (cap_src),
    .cap_dst  (cap_dst),
    .elem_end (elem_end),
    .op_q     (op_q),
    .rep_q    (rep_q),
    .word_q   (word_q)
  );

  strop_step #(.AW(AW)) u_step_si (.ptr(si_q), .down(dir_q), .word(word_q), .nxt(si_nx));
  strop_step #(.AW(AW)) u_step_di (.ptr(di_q), .down(dir_q), .word(word_q), .nxt(di_nx));

  assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : opa_w;

  strop_cmpz #(.BW(BW)) u_cmpz (.lhs(cmp_lhs), .rhs(opb_w), .word(word_q), .is_zero(eq_w));

  // Operand capture, one byte lane per element byte
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW-1:0] a_q, a_d, b_q, b_d;
    logic          hit;

    always_comb begin
      hit = (byte_sel == 1'(l));
      a_d = (cap_src && hit) ? mem_rdata : a_q;
      b_d = (cap_dst && hit) ? mem_rdata : b_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end

    assign opa_w[l*BW +: BW] = a_q;
    assign opb_w[l*BW +: BW] = b_q;
  end

  // Memory port
  assign base      = use_di ? di_q : si_q;
  assign mem_addr  = base + AW'(byte_sel);
  assign wsrc      = (op_q == OP_STORE) ? acc_q : opa_w;
  assign mem_wdata = byte_sel ? wsrc[WW-1:BW] : wsrc[BW-1:0];

  // Architectural register next state
  always_comb begin
    si_d  = si_q;
    di_d  = di_q;
    cx_d  = cx_q;
    acc_d = acc_q;
    dir_d = dir_q;
    zf_d  = zf_q;
    if (cfg_load && !busy_w) begin
      si_d  = cfg_si;
      di_d  = cfg_di;
      cx_d  = cfg_cx;
      acc_d = cfg_acc;
      dir_d = cfg_dir;
    end
    if (elem_end) begin
      if (steps_si(op_q))    si_d = si_nx;
      if (steps_di(op_q))    di_d = di_nx;
      if (rep_q != RP_NONE)  cx_d = cx_q - CW'(1);
      if (op_q == OP_LOAD)   acc_d = word_q ? opa_w : {acc_q[WW-1:BW], opa_w[BW-1:0]};
      if (compares(op_q))    zf_d = eq_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q  <= '0;
      di_q  <= '0;
      cx_q  <= '0;
      acc_q <= '0;
      dir_q <= 1'b0;
      zf_q  <= 1'b0;
    end else begin
      si_q  <= si_d;
      di_q  <= di_d;
      cx_q  <= cx_d;
      acc_q <= acc_d;
      dir_q <= dir_d;
      zf_q  <= zf_d;
    end
  end

  assign si   = si_q;
  assign di   = di_q;
  assign cx   = cx_q;
  assign acc  = acc_q;
  assign dir  = dir_q;
  assign zf   = zf_q;
  assign busy = busy_w;

  // R6: single-element commands never alter the count
  a_r6_cx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && (rep_q == RP_NONE)) |=> (cx_q == $past(cx_q)));
  // R2: pointers an operation does not use stay put
  a_r2_si_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !steps_si(op_q)) |=> $stable(si_q));
  a_r2_di_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !steps_di(op_q)) |=> $stable(di_q));
  // R5: only compare and scan touch the zero flag
  a_r5_zf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !compares(op_q)) |=> $stable(zf_q));
  // R10: a load strobe while busy leaves the direction flag alone
  a_r10_dir_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(dir_q));

endmodule

// File: tb/strop_seq_bench.sv
module strop_seq_bench;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [AW-1:0] cfg_si, cfg_di;
  logic [CW-1:0] cfg_cx;
  logic [15:0]   cfg_acc;
  logic          cfg_dir;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_rep;
  logic          cmd_word;
  logic [AW-1:0] si, di;
  logic [CW-1:0] cx;
  logic [15:0]   acc;
  logic          dir, zf, busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  strop_seq #(.AW(AW), .CW(CW)) u_strop_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_si(cfg_si), .cfg_di(cfg_di), .cfg_cx(cfg_cx),
    .cfg_acc(cfg_acc), .cfg_dir(cfg_dir),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rep(cmd_rep), .cmd_word(cmd_word),
    .si(si), .di(di), .cx(cx), .acc(acc), .dir(dir), .zf(zf),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: 256 bytes, one-cycle read latency, bench fill path
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic       fill_en;
  logic [7:0] fill_a, fill_d;

  always @(posedge clk) begin
    if (fill_en) mem[fill_a] = fill_d;
    else if (mem_req && mem_we) mem[mem_addr[7:0]] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
  end

  int checks = 0;
  int errors = 0;

  logic [15:0] e_si, e_di, e_cx, e_acc;
  logic        e_dir, e_zf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] p, input logic w);
    logic [15:0] q;
    q = p + 16'd1;
    return w ? {shadow[q[7:0]], shadow[p[7:0]]} : {8'h00, shadow[p[7:0]]};
  endfunction

  task automatic wr(input logic [15:0] p, input logic w, input logic [15:0] v);
    logic [15:0] q;
    q = p + 16'd1;
    shadow[p[7:0]] = v[7:0];
    if (w) shadow[q[7:0]] = v[15:8];
  endtask

  function automatic logic [15:0] stepp(input logic [15:0] p, input logic w);
    logic [15:0] d;
    d = w ? 16'd2 : 16'd1;
    return e_dir ? p - d : p + d;
  endfunction

  // Reference model of one command, from the requirements
  task automatic ref_exec(input int op, input int rep, input logic w);
    logic [15:0] a, b;
    if (rep != 0 && e_cx == 16'd0) return;
    forever begin
      case (op)
        0: wr(e_di, w, rd(e_si, w));
        1: begin
          a = rd(e_si, w); b = rd(e_di, w);
          e_zf = (a == b);
        end
        2: begin
          a = w ? e_acc : {8'h00, e_acc[7:0]}; b = rd(e_di, w);
          e_zf = (a == b);
        end
        3: begin
          a = rd(e_si, w);
          e_acc = w ? a : {e_acc[15:8], a[7:0]};
        end
        default: wr(e_di, w, e_acc);
      endcase
      if (op == 0 || op == 1 || op == 3) e_si = stepp(e_si, w);
      if (op != 3) e_di = stepp(e_di, w);
      if (rep == 0) break;
      e_cx = e_cx - 16'd1;
      if (e_cx == 16'd0) break;
      if ((op == 1 || op == 2) && ((rep == 2 && !e_zf) || (rep == 3 && e_zf))) break;
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    fill_en = 1'b1; fill_a = a; fill_d = d;
    shadow[a] = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) begin
      fill_en = 1'b1; fill_a = 8'(i); fill_d = 8'($urandom % 4);
      shadow[i] = fill_d;
      @(negedge clk);
    end
    fill_en = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                     input logic [15:0] a, input logic dr);
    cfg_load = 1'b1; cfg_si = s; cfg_di = d; cfg_cx = c; cfg_acc = a; cfg_dir = dr;
    @(negedge clk);
    cfg_load = 1'b0;
    e_si = s; e_di = d; e_cx = c; e_acc = a; e_dir = dr;
  endtask

  int reqs;

  task automatic run_cmd(input int op, input int rep, input logic w, input logic inject);
    int cyc;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_rep = 2'(rep); cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    reqs = 0;
    cyc = 0;
    while (done !== 1'b1) begin
      if (mem_req === 1'b1) reqs++;
      if (inject && cyc == 0) begin
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_rep = 2'd1; cmd_word = 1'b1;
        cfg_load = 1'b1; cfg_si = 16'h00AA; cfg_di = 16'h00BB; cfg_cx = 16'd9;
        cfg_acc = 16'h5A5A; cfg_dir = ~e_dir;
      end else begin
        cmd_valid = 1'b0; cfg_load = 1'b0;
      end
      cyc++;
      if (cyc > 4000) break;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cfg_load = 1'b0;
    if (done !== 1'b1) begin
      chk("R10 watchdog done never seen", 32'd0, 32'd1);
    end else begin
      chk("R10 busy during done", busy, 1'b1);
      @(negedge clk);
      chk("R10 done single cycle", done, 1'b0);
      chk("R10 busy low after done", busy, 1'b0);
    end
  endtask

  task automatic check_all(input string ctx);
    int bad;
    chk({"R2 si ", ctx}, si, e_si);
    chk({"R2 di ", ctx}, di, e_di);
    chk({"R7 cx ", ctx}, cx, e_cx);
    chk({"R4 acc ", ctx}, acc, e_acc);
    chk({"R5 zf ", ctx}, zf, e_zf);
    chk({"R10 dir ", ctx}, dir, e_dir);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    chk({"R3 memory image ", ctx}, bad, 0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_si = '0; cfg_di = '0; cfg_cx = '0;
    cfg_acc = '0; cfg_dir = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_rep = '0;
    cmd_word = 1'b0; fill_en = 1'b0; fill_a = '0; fill_d = '0;
    e_si = '0; e_di = '0; e_cx = '0; e_acc = '0; e_dir = 1'b0; e_zf = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 mem_req", mem_req, 1'b0);
    chk("R1 mem_we", mem_we, 1'b0);
    chk("R1 regs", {si, di, cx, acc}, 64'h0);
    chk("R1 flags", {dir, zf}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    fill_random();

    // R8 while-equal compare stops on the third byte
    put(8'h10, 8'h05); put(8'h11, 8'h05); put(8'h12, 8'h07);
    put(8'h40, 8'h05); put(8'h41, 8'h05); put(8'h42, 8'h09);
    cfg(16'h0010, 16'h0040, 16'd5, 16'h0000, 1'b0);
    ref_exec(1, 2, 1'b0);
    run_cmd(1, 2, 1'b0, 1'b0);
    chk("R8 repe cx", cx, 16'd2);
    chk("R8 repe si", si, 16'h0013);
    chk("R5 repe zf", zf, 1'b0);
    check_all("repe cmp");

    // R8 while-not-equal scan finds the match
    put(8'h80, 8'h01); put(8'h81, 8'h02); put(8'h82, 8'h33); put(8'h83, 8'h04);
    cfg(16'h0000, 16'h0080, 16'd10, 16'h1233, 1'b0);
    ref_exec(2, 3, 1'b0);
    run_cmd(2, 3, 1'b0, 1'b0);
    chk("R8 repne cx", cx, 16'd7);
    chk("R8 repne di", di, 16'h0083);
    chk("R5 repne zf", zf, 1'b1);
    check_all("repne scan");

    // R3 R2 word move downward
    put(8'h30, 8'hA1); put(8'h31, 8'hB2); put(8'h2E, 8'hC3); put(8'h2F, 8'hD4);
    cfg(16'h0030, 16'h0060, 16'd2, 16'h0000, 1'b1);
    ref_exec(0, 1, 1'b1);
    run_cmd(0, 1, 1'b1, 1'b0);
    chk("R3 word low byte", {mem[8'h60], mem[8'h5E]}, 16'hA1C3);
    chk("R3 word high byte", {mem[8'h61], mem[8'h5F]}, 16'hB2D4);
    chk("R2 down si", si, 16'h002C);
    check_all("word move down");

    // R7 zero count: no memory traffic
    cfg(16'h0020, 16'h0070, 16'd0, 16'hBEEF, 1'b0);
    ref_exec(4, 1, 1'b1);
    run_cmd(4, 1, 1'b1, 1'b0);
    chk("R7 zero count requests", reqs, 0);
    check_all("zero count");

    // R6 R4 single word load
    put(8'h50, 8'h34); put(8'h51, 8'h12);
    cfg(16'h0050, 16'h0000, 16'd9, 16'h0000, 1'b0);
    ref_exec(3, 0, 1'b1);
    run_cmd(3, 0, 1'b1, 1'b0);
    chk("R4 load word acc", acc, 16'h1234);
    chk("R6 cx unchanged", cx, 16'd9);
    check_all("single load");

    // R11 illegal operation code
    cfg(16'h0011, 16'h0022, 16'd3, 16'h7777, 1'b0);
    cmd_valid = 1'b1; cmd_op = 3'd6; cmd_rep = 2'd1; cmd_word = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 illegal op busy", busy, 1'b0);
    @(negedge clk);
    chk("R11 illegal op mem_req", mem_req, 1'b0);
    check_all("R11 illegal op");

    // R10 command and register load during busy are ignored
    cfg(16'h0090, 16'h00C0, 16'd3, 16'h0000, 1'b0);
    ref_exec(0, 1, 1'b0);
    run_cmd(0, 1, 1'b0, 1'b1);
    check_all("R10 busy inject");

    // Random mix
    for (int n = 0; n < 80; n++) begin
      int op, rep;
      logic w;
      if (n % 16 == 0) fill_random();
      op  = $urandom % 5;
      rep = $urandom % 4;
      w   = 1'($urandom % 2);
      cfg(16'($urandom % 256), 16'($urandom % 256), 16'($urandom % 7),
          16'($urandom % 4) | (16'($urandom % 4) << 8), 1'($urandom % 2));
      ref_exec(op, rep, w);
      run_cmd(op, rep, w, 1'b0);
      check_all($sformatf("random %0d op %0d rep %0d w %0d", n, op, rep, w));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule